// File: doc/BRIEF.md
# Single-Frame Buffered Network Port

This block is a small memory-mapped network port. It keeps exactly one received frame and one outgoing frame in on-chip byte stores. A host moves data through a short register window. It drains a received frame one byte per read of a data register, and it builds an outgoing frame by first writing its length and then writing its bytes one at a time. Completion of either direction raises a flag in an interrupt-control word. A single level interrupt line is high while any flag is set.

The network side has two byte streams, each with valid and last markers. The inbound stream carries whole frames into the receive store. The block accepts a frame only while it is idle and has room. Otherwise the frame is discarded in full, and bytes past the store size are cut off. The outbound stream plays back each completed transmit frame at one byte per cycle and takes no backpressure. A busy flag follows the pending interrupt flags. Writing the interrupt-control word clears flags in a fixed priority, and a self-test bit in that word resets the whole device.

Two state machines run the datapath. The receive machine has states RX_IDLE (waiting for a first byte), RX_FILL (storing an accepted frame) and RX_DROP (discarding until the last byte). From RX_IDLE, a first byte goes to RX_FILL when reception is allowed and to RX_DROP when it is not. A single-byte frame stays in RX_IDLE. From RX_FILL, a last byte returns to RX_IDLE, and loss of permission or a self-test reset goes to RX_DROP. From RX_DROP, a last byte returns to RX_IDLE. The transmit machine has TX_IDLE and TX_SEND. It leaves TX_IDLE when a frame completes, returns from TX_SEND after the byte marked last, restarts TX_SEND if another frame completes, and falls to TX_IDLE on self-test reset.

Top module: `fbn_nic`

## Requirements
- R1: Only host address bits [5:0] are decoded. Offset 0x00 reads parameter ID_WORD0 and 0x04 reads ID_WORD1. 0x08 reads busy in bit 0, 0x0C the receive count, 0x10 the transmit count and 0x14 the interrupt-control word. Offsets 0x18 and 0x20 and any other offset read 0. Read data appears on host_rdata in the cycle after the request.
- R2: After reset, busy reads 1, both counts read 0, the interrupt-control word reads 0 and irq is low.
- R3: A write to 0x10 stores the value if it is at most MAX_FRAME and stores 0 otherwise. Every such write also returns the transmit byte index to 0.
- R4: Each write to 0x20 stores wdata[7:0] at the transmit index and advances it. When the index reaches the count, the frame goes out on tx_data in write order, tx_last marks its final byte, the count returns to 0, TX-done (bit 0) is set and busy becomes 1.
- R5: A read of 0x1C while the receive count is nonzero returns the next stored byte and decrements the count. With the count at 0 it returns 0 and changes nothing.
- R6: A read of 0x14 returns the word as it stands (test bit at bit 31, RX-done at bit 1, TX-done at bit 0) and then clears the test bit.
- R7: A write to 0x14 acts on the first match. Bit 0 clears TX-done. Otherwise bit 1 clears RX-done. Otherwise bit 31 resets the device and sets the test bit. A zero changes no flag. Afterwards busy equals 1 exactly when some flag remains set.
- R8: irq is high exactly when the interrupt-control word is nonzero.
- R9: An inbound frame is accepted only if busy is 0 and the receive count is below MAX_FRAME when its bytes arrive. Acceptance sets the count to the frame length, rewinds the read index, sets RX-done and sets busy. A frame that arrives while reception is not allowed leaves every register unchanged.
- R10: An inbound frame longer than MAX_FRAME is cut to its first MAX_FRAME bytes, and the count reads MAX_FRAME.
- R11: Writes to 0x00, 0x04, 0x08, 0x0C and 0x1C have no effect.
- R12: The self-test reset of R7 also clears the receive count and the transmit count.
- R13: A write to 0x20 while the transmit count is 0 sends nothing and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | ADDR_W | Byte address; bits [5:0] decoded |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered one cycle after the request |
| irq | output | 1 | Level interrupt, high while any flag is set |
| rx_valid | input | 1 | Inbound byte valid |
| rx_data | input | 8 | Inbound byte |
| rx_last | input | 1 | Inbound byte is the final byte of its frame |
| tx_valid | output | 1 | Outbound byte valid |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Outbound byte is the final byte of its frame |

## Verification
The bench builds the block with MAX_FRAME set to 16 and ADDR_W set to 8. The small store lets a 20-byte inbound frame reach the truncation limit. It also lets a count write of 17 reach the over-limit rule of R3, all within a few hundred cycles. The eight-bit address makes the aliasing of R1 reachable: 0x44 must read the same as 0x04. The ID words keep their defaults.

// File: rtl/fbn_pkg.sv
package fbn_pkg;

    localparam logic [5:0] OFF_ID0    = 6'h00;
    localparam logic [5:0] OFF_ID1    = 6'h04;
    localparam logic [5:0] OFF_BUSY   = 6'h08;
    localparam logic [5:0] OFF_RXCNT  = 6'h0C;
    localparam logic [5:0] OFF_TXCNT  = 6'h10;
    localparam logic [5:0] OFF_INTCTL = 6'h14;
    localparam logic [5:0] OFF_INFO   = 6'h18;
    localparam logic [5:0] OFF_RXDATA = 6'h1C;
    localparam logic [5:0] OFF_TXDATA = 6'h20;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_FILL,
        RX_DROP
    } rx_state_t;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_t;

    typedef struct packed {
        logic test;
        logic rx;
        logic tx;
    } int_flags_t;

endpackage

// File: rtl/fbn_rx_store.sv
module fbn_rx_store
    import fbn_pkg::*;
#(
    parameter int MAX_FRAME = 1514
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 soft_rst,
    input  logic                                 in_valid,
    input  logic [7:0]                           in_data,
    input  logic                                 in_last,
    input  logic                                 allow,
    input  logic                                 pop,
    output logic                                 commit,
    output logic [$clog2(MAX_FRAME+1)-1:0]       count,
    output logic [7:0]                           rd_byte
);
    localparam int CNT_W = $clog2(MAX_FRAME + 1);
    localparam int IDX_W = $clog2(MAX_FRAME);

    rx_state_t        st_q, st_d;
    logic [CNT_W-1:0] wlen_q, wlen_d, len_d, cnt_q;
    logic [IDX_W-1:0] rd_q;
    logic             wr_en;
    logic [7:0]       mem [MAX_FRAME];

    // next-state and datapath controls
    always_comb begin
        st_d   = st_q;
        wlen_d = wlen_q;
        wr_en  = 1'b0;
        commit = 1'b0;
        len_d  = (wlen_q < CNT_W'(MAX_FRAME)) ? wlen_q + 1'b1 : wlen_q;
        if (soft_rst) begin
            wlen_d = '0;
            if (in_valid) begin
                st_d = in_last ? RX_IDLE : RX_DROP;
            end else if (st_q == RX_FILL) begin
                st_d = RX_DROP;
            end
        end else if (in_valid) begin
            unique case (st_q)
                RX_IDLE, RX_FILL: begin
                    if (allow) begin
                        wr_en  = (wlen_q < CNT_W'(MAX_FRAME));
                        wlen_d = len_d;
                        if (in_last) begin
                            commit = 1'b1;
                            st_d   = RX_IDLE;
                            wlen_d = '0;
                        end else begin
                            st_d = RX_FILL;
                        end
                    end else begin
                        wlen_d = '0;
                        st_d   = in_last ? RX_IDLE : RX_DROP;
                    end
                end
                RX_DROP: begin
                    if (in_last) st_d = RX_IDLE;
                end
                default: st_d = RX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RX_IDLE;
            wlen_q <= '0;
        end else begin
            st_q   <= st_d;
            wlen_q <= wlen_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wlen_q[IDX_W-1:0]] <= in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rd_q  <= '0;
        end else if (soft_rst) begin
            cnt_q <= '0;
            rd_q  <= '0;
        end else if (commit) begin
            cnt_q <= len_d;
            rd_q  <= '0;
        end else if (pop && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            rd_q  <= rd_q + 1'b1;
        end
    end

    assign count   = cnt_q;
    assign rd_byte = mem[rd_q];

endmodule

// File: rtl/fbn_tx_store.sv
module fbn_tx_store
    import fbn_pkg::*;
#(
    parameter int MAX_FRAME = 1514
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 soft_rst,
    input  logic                                 cnt_wr,
    input  logic [31:0]                          cnt_val,
    input  logic                                 dat_wr,
    input  logic [7:0]                           dat_byte,
    output logic [$clog2(MAX_FRAME+1)-1:0]       count,
    output logic                                 done,
    output logic                                 out_valid,
    output logic [7:0]                           out_data,
    output logic                                 out_last
);
    localparam int CNT_W = $clog2(MAX_FRAME + 1);
    localparam int IDX_W = $clog2(MAX_FRAME);

    tx_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, widx_q, len_q, ptr_q;
    logic             at_end;
    logic [7:0]       mem [MAX_FRAME];

    assign done   = dat_wr && (cnt_q != '0) && (widx_q + 1'b1 == cnt_q);
    assign at_end = (ptr_q + 1'b1 == len_q);

    // loading side: count and write index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            widx_q <= '0;
        end else if (soft_rst) begin
            cnt_q  <= '0;
            widx_q <= '0;
        end else if (cnt_wr) begin
            cnt_q  <= (cnt_val > 32'(MAX_FRAME)) ? '0 : cnt_val[CNT_W-1:0];
            widx_q <= '0;
        end else if (dat_wr && cnt_q != '0) begin
            if (done) begin
                cnt_q  <= '0;
                widx_q <= '0;
            end else begin
                widx_q <= widx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (dat_wr && cnt_q != '0) mem[widx_q[IDX_W-1:0]] <= dat_byte;
    end

    // emitter next state
    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d = TX_IDLE;
        end else begin
            unique case (st_q)
                TX_IDLE: if (done) st_d = TX_SEND;
                TX_SEND: if (!done && at_end) st_d = TX_IDLE;
                default: st_d = TX_IDLE;
            endcase
        end
    end

    // emitter state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TX_IDLE;
            len_q <= '0;
            ptr_q <= '0;
        end else begin
            st_q <= st_d;
            if (done) begin
                len_q <= cnt_q;
                ptr_q <= '0;
            end else if (st_q == TX_SEND) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // emitter outputs
    always_comb begin
        out_valid = (st_q == TX_SEND);
        out_data  = out_valid ? mem[ptr_q[IDX_W-1:0]] : 8'h00;
        out_last  = out_valid && at_end;
    end

    assign count = cnt_q;

endmodule

// File: rtl/fbn_nic.sv
module fbn_nic
    import fbn_pkg::*;
#(
    parameter int          MAX_FRAME = 1514,
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] ID_WORD0  = 32'h4642_4E49,
    parameter logic [31:0] ID_WORD1  = 32'h4330_3031
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last
);
    localparam int CNT_W = $clog2(MAX_FRAME + 1);

    logic [5:0]       off;
    logic             rd_req, wr_req, int_wr, soft_rst, pop, cnt_wr, dat_wr;
    logic             busy_q, busy_d, allow, rx_commit, tx_done;
    int_flags_t       flg_q, flg_d;
    logic [CNT_W-1:0] rx_cnt, tx_cnt;
    logic [7:0]       rx_byte;
    logic [31:0]      intctl;

    assign off      = host_addr[5:0];
    assign rd_req   = host_req && !host_wr;
    assign wr_req   = host_req && host_wr;
    assign int_wr   = wr_req && (off == OFF_INTCTL);
    assign soft_rst = int_wr && !host_wdata[0] && !host_wdata[1] && host_wdata[31];
    assign pop      = rd_req && (off == OFF_RXDATA);
    assign cnt_wr   = wr_req && (off == OFF_TXCNT);
    assign dat_wr   = wr_req && (off == OFF_TXDATA);
    assign allow    = !busy_q && (rx_cnt < CNT_W'(MAX_FRAME));
    assign intctl   = {flg_q.test, 29'b0, flg_q.rx, flg_q.tx};
    assign irq      = |intctl;

    fbn_rx_store #(.MAX_FRAME(MAX_FRAME)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .in_valid (rx_valid),
        .in_data  (rx_data),
        .in_last  (rx_last),
        .allow    (allow),
        .pop      (pop),
        .commit   (rx_commit),
        .count    (rx_cnt),
        .rd_byte  (rx_byte)
    );

    fbn_tx_store #(.MAX_FRAME(MAX_FRAME)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .cnt_wr    (cnt_wr),
        .cnt_val   (host_wdata),
        .dat_wr    (dat_wr),
        .dat_byte  (host_wdata[7:0]),
        .count     (tx_cnt),
        .done      (tx_done),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_last  (tx_last)
    );

    // flag and busy next values
    always_comb begin
        flg_d  = flg_q;
        busy_d = busy_q;
        if (soft_rst) begin
            flg_d      = '0;
            flg_d.test = 1'b1;
            busy_d     = 1'b1;
        end else begin
            if (rd_req && off == OFF_INTCTL) flg_d.test = 1'b0;
            if (int_wr) begin
                if (host_wdata[0])      flg_d.tx = 1'b0;
                else if (host_wdata[1]) flg_d.rx = 1'b0;
            end
            if (tx_done)   flg_d.tx = 1'b1;
            if (rx_commit) flg_d.rx = 1'b1;
            if (tx_done || rx_commit) busy_d = 1'b1;
            else if (int_wr)          busy_d = flg_d.tx | flg_d.rx | flg_d.test;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q  <= '0;
            busy_q <= 1'b1;
        end else begin
            flg_q  <= flg_d;
            busy_q <= busy_d;
        end
    end

    // registered read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (rd_req) begin
            case (off)
                OFF_ID0:    host_rdata <= ID_WORD0;
                OFF_ID1:    host_rdata <= ID_WORD1;
                OFF_BUSY:   host_rdata <= {31'b0, busy_q};
                OFF_RXCNT:  host_rdata <= 32'(rx_cnt);
                OFF_TXCNT:  host_rdata <= 32'(tx_cnt);
                OFF_INTCTL: host_rdata <= intctl;
                OFF_RXDATA: host_rdata <= (rx_cnt != '0) ? {24'b0, rx_byte} : 32'h0;
                default:    host_rdata <= 32'h0;
            endcase
        end
    end

endmodule

// File: rtl/fbn_nic_chk.sv
module fbn_nic_chk #(
    parameter int MAX_FRAME = 1514
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              host_req,
    input logic                              host_wr,
    input logic [5:0]                        off,
    input logic [31:0]                       host_wdata,
    input logic                              busy,
    input logic                              f_tx,
    input logic                              f_rx,
    input logic                              f_test,
    input logic [$clog2(MAX_FRAME+1)-1:0]    rx_cnt,
    input logic [$clog2(MAX_FRAME+1)-1:0]    tx_cnt,
    input logic                              tx_done,
    input logic                              rx_commit,
    input logic                              tx_valid,
    input logic                              tx_last
);
    localparam int CNT_W = $clog2(MAX_FRAME + 1);

    AST_TXDONE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> (busy && f_tx)); // R4

    AST_LAST_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R4

    AST_COMMIT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_commit |-> !busy); // R9

    AST_RXCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CNT_W'(MAX_FRAME)); // R10

    AST_TXCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CNT_W'(MAX_FRAME)); // R3

    AST_TEST_CLEARED_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_wr && off == 6'h14) |=> !f_test); // R6

    AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_wr && off == 6'h1C && rx_cnt != '0 && !rx_commit)
        |=> (rx_cnt == $past(rx_cnt) - 1'b1)); // R5

    AST_ZERO_WRITE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_wr && off == 6'h14 && host_wdata == 32'h0 && !rx_commit)
        |=> ($stable(f_tx) && $stable(f_rx) && $stable(f_test))); // R7

endmodule

bind fbn_nic fbn_nic_chk #(.MAX_FRAME(MAX_FRAME)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_wr    (host_wr),
    .off        (host_addr[5:0]),
    .host_wdata (host_wdata),
    .busy       (busy_q),
    .f_tx       (flg_q.tx),
    .f_rx       (flg_q.rx),
    .f_test     (flg_q.test),
    .rx_cnt     (rx_cnt),
    .tx_cnt     (tx_cnt),
    .tx_done    (tx_done),
    .rx_commit  (rx_commit),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last)
);

// File: tb/tb_fbn_nic.sv
module tb_fbn_nic;
    localparam int          CLK_PERIOD = 10;
    localparam int          MAXF       = 16;
    localparam logic [31:0] ID0        = 32'h4642_4E49;
    localparam logic [31:0] ID1        = 32'h4330_3031;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;

    int checks = 0;
    int errors = 0;
    int cap_n = 0;
    int frames_n = 0;
    logic [7:0] cap [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    fbn_nic #(.MAX_FRAME(MAXF), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    always @(negedge clk) begin
        if (tx_valid) begin
            cap[cap_n % 64] = tx_data;
            cap_n++;
            if (tx_last) frames_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_addr = a;
        @(negedge clk);
        d = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp,
                          input string tag, input string what);
        logic [31:0] v;
        bus_rd(a, v);
        chk(v === exp, tag, what, v, exp);
    endtask

    task automatic send_frame(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = base + 8'(i); rx_last = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic t_reset;
        chk(irq === 1'b0, "R2", "irq after reset", {31'b0, irq}, 32'h0);
        rd_chk(8'h08, 32'h1, "R2", "busy after reset");
        rd_chk(8'h0C, 32'h0, "R2", "rx count after reset");
        rd_chk(8'h10, 32'h0, "R2", "tx count after reset");
        rd_chk(8'h14, 32'h0, "R2", "intctl after reset");
    endtask

    task automatic t_decode;
        rd_chk(8'h00, ID0, "R1", "id word 0");
        rd_chk(8'h04, ID1, "R1", "id word 1");
        rd_chk(8'h44, ID1, "R1", "alias of 0x04 at 0x44");
        rd_chk(8'h18, 32'h0, "R1", "info reads 0");
        rd_chk(8'h20, 32'h0, "R1", "tx data port reads 0");
        rd_chk(8'h02, 32'h0, "R1", "unmapped offset");
    endtask

    task automatic t_readonly;
        bus_wr(8'h08, 32'h0);
        bus_wr(8'h0C, 32'h5);
        bus_wr(8'h00, 32'h1234);
        bus_wr(8'h1C, 32'hFF);
        rd_chk(8'h08, 32'h1, "R11", "busy ignores write");
        rd_chk(8'h0C, 32'h0, "R11", "rx count ignores write");
        rd_chk(8'h00, ID0, "R11", "id ignores write");
    endtask

    task automatic t_rx_while_busy_at_start;
        send_frame(3, 8'h70);
        rd_chk(8'h0C, 32'h0, "R9", "frame dropped while busy");
        rd_chk(8'h14, 32'h0, "R9", "no flag from dropped frame");
        bus_wr(8'h14, 32'h0);
        rd_chk(8'h08, 32'h0, "R7", "zero write drops busy");
    endtask

    task automatic t_rx_basic;
        send_frame(5, 8'h10);
        rd_chk(8'h0C, 32'd5, "R9", "rx count = length");
        chk(irq === 1'b1, "R8", "irq with RX-done", {31'b0, irq}, 32'h1);
        rd_chk(8'h14, 32'h2, "R9", "RX-done set");
        rd_chk(8'h08, 32'h1, "R9", "busy set on accept");
        for (int i = 0; i < 3; i++) rd_chk(8'h1C, 32'h10 + i, "R5", "rx byte");
        rd_chk(8'h0C, 32'd2, "R5", "count after 3 reads");
        send_frame(4, 8'h90);
        rd_chk(8'h0C, 32'd2, "R9", "frame dropped while busy set");
        bus_wr(8'h14, 32'h2);
        rd_chk(8'h14, 32'h0, "R7", "RX-done cleared");
        chk(irq === 1'b0, "R8", "irq low with no flag", {31'b0, irq}, 32'h0);
        rd_chk(8'h08, 32'h0, "R7", "busy clears with flags");
        rd_chk(8'h1C, 32'h13, "R5", "rx byte 3");
        rd_chk(8'h1C, 32'h14, "R5", "rx byte 4");
        rd_chk(8'h1C, 32'h0, "R5", "empty read returns 0");
        rd_chk(8'h0C, 32'h0, "R5", "empty read keeps count 0");
    endtask

    task automatic t_rx_trunc;
        send_frame(20, 8'h40);
        rd_chk(8'h0C, MAXF, "R10", "truncated count");
        for (int i = 0; i < MAXF; i++) rd_chk(8'h1C, 32'h40 + i, "R10", "truncated byte");
        rd_chk(8'h1C, 32'h0, "R10", "nothing past limit");
        bus_wr(8'h14, 32'h2);
    endtask

    task automatic t_tx;
        bus_wr(8'h10, 32'd17);
        rd_chk(8'h10, 32'h0, "R3", "over-limit count stores 0");
        bus_wr(8'h10, MAXF);
        rd_chk(8'h10, MAXF, "R3", "count at limit");
        bus_wr(8'h10, 32'd3);
        bus_wr(8'h20, 32'h11);
        bus_wr(8'h20, 32'h22);
        bus_wr(8'h10, 32'd3);
        cap_n = 0; frames_n = 0;
        bus_wr(8'h20, 32'hA0);
        bus_wr(8'h20, 32'hA1);
        chk(frames_n == 0, "R3", "index reset kept frame open", frames_n, 0);
        bus_wr(8'h20, 32'hA2);
        repeat (5) @(negedge clk);
        chk(frames_n == 1, "R4", "one frame out", frames_n, 1);
        chk(cap_n == 3, "R4", "frame length", cap_n, 3);
        chk(cap[0] == 8'hA0 && cap[1] == 8'hA1 && cap[2] == 8'hA2, "R4", "frame bytes",
            {8'h0, cap[0], cap[1], cap[2]}, 32'h00A0A1A2);
        rd_chk(8'h10, 32'h0, "R4", "count back to 0");
        rd_chk(8'h14, 32'h1, "R4", "TX-done set");
        rd_chk(8'h08, 32'h1, "R4", "busy after send");
    endtask

    task automatic t_tx_zero_count;
        bus_wr(8'h14, 32'h1);
        rd_chk(8'h14, 32'h0, "R7", "TX-done cleared");
        cap_n = 0; frames_n = 0;
        bus_wr(8'h20, 32'h55);
        repeat (4) @(negedge clk);
        chk(cap_n == 0, "R13", "no bytes out", cap_n, 0);
        rd_chk(8'h14, 32'h0, "R13", "no flag set");
    endtask

    task automatic t_priority_and_test;
        send_frame(4, 8'h30);
        bus_wr(8'h10, 32'd1);
        bus_wr(8'h20, 32'h5A);
        repeat (3) @(negedge clk);
        rd_chk(8'h14, 32'h3, "R7", "both flags pending");
        bus_wr(8'h14, 32'h8000_0003);
        rd_chk(8'h14, 32'h2, "R7", "bit0 has priority");
        rd_chk(8'h08, 32'h1, "R7", "busy with RX-done left");
        bus_wr(8'h14, 32'h8000_0002);
        rd_chk(8'h14, 32'h0, "R7", "bit1 before test bit");
        rd_chk(8'h0C, 32'd4, "R12", "rx count before test");
        bus_wr(8'h10, 32'd5);
        bus_wr(8'h14, 32'h8000_0000);
        chk(irq === 1'b1, "R8", "irq on test bit", {31'b0, irq}, 32'h1);
        rd_chk(8'h08, 32'h1, "R7", "busy after test reset");
        rd_chk(8'h0C, 32'h0, "R12", "rx count cleared");
        rd_chk(8'h10, 32'h0, "R12", "tx count cleared");
        rd_chk(8'h14, 32'h8000_0000, "R6", "test bit returned");
        rd_chk(8'h14, 32'h0, "R6", "test bit cleared by read");
        chk(irq === 1'b0, "R8", "irq low after read", {31'b0, irq}, 32'h0);
        bus_wr(8'h14, 32'h0);
        rd_chk(8'h08, 32'h0, "R7", "ack releases busy");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_readonly();
        t_rx_while_busy_at_start();
        t_rx_basic();
        t_rx_trunc();
        t_tx();
        t_tx_zero_count();
        t_priority_and_test();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule